// File: doc/BRIEF.md
# Tape Controller Register Interface

This block is the bus-slave register front end of a magnetic tape controller serving up to eight drives. A host addresses six word registers through a 3-bit word offset, using word or byte writes. The block holds the command, byte-count, memory-address and 8-bit data-buffer registers. It assembles a read-only status word from sticky error flags and the live status bits of whichever drive the command register selects.

When the host sets the go bit, the block checks whether the selected drive can accept the function. If the function is legal, the block issues a one-cycle start pulse carrying the function code and unit number. If not, it flags an illegal operation. The data path reports the end of an operation back through a completion strobe with error flags. The block maintains the done, error-summary and interrupt-request outputs. Data movement, drive mechanics and interrupt vectoring sit outside.

Top module: `tape_ctl_regs`

## Requirements
- R1: After reset the command register reads 0x0080 (only done set), byte count, memory address and data buffer read 0, `irq_o` and `err_o` are 0, and `done_o` is 1.
- R2: `addr_i[3:1]` selects the register: 0 status, 1 command, 2 byte count, 3 memory address, 4 data buffer, 5 read lines. Offsets 6 and 7 read 0. Writes to offsets 0 and 5 change nothing.
- R3: A word write (`byte_i`=0) loads all 16 bits. A byte write takes its data from `wdata_i[7:0]` and replaces the high byte when `addr_i[0]`=1 or the low byte when `addr_i[0]`=0. The data buffer keeps only bits 7:0, and a high-byte write to it is ignored.
- R4: Command bit positions: go 0, function 3:1, address extension 5:4, interrupt enable 6, done 7, unit 10:8, parity select 11, init 12, density 14:13, error 15. Go and init always read 0. Done and error cannot be written.
- R5: Status bit positions: illegal 15, end-of-file 14, CRC 13, parity 12, data late 11, end-of-tape 10, record length 9, bad tape 8, nonexistent memory 7, online 6, beginning-of-tape 5, write lock 2, rewinding 1, ready 0. Bits 14, 10, 6, 5, 2 and 1 come from the selected unit's inputs. Ready is the inverse of its busy input. Bits 4 and 3 read 0.
- R6: A command write while done is clear sets the illegal flag and changes nothing else.
- R7: A command write with init set, while done is set, returns every register and flag (read lines included) to the reset state.
- R8: An accepted command write with interrupt enable clear drops `irq_o`. One with interrupt enable set, when it was clear before and done or error is set, raises `irq_o`.
- R9: `err_o` and command bit 15 equal the OR of status bits 15 to 7.
- R10: Each read of the read-lines register toggles its bit 15 before returning it. All other bits read 0, so the first read after reset returns 0x8000.
- R11: A go is illegal when the newly selected unit is offline, busy, or write-locked with function 2 (write), 3 (write file mark) or 6 (write with extended gap). An illegal go sets the illegal flag, leaves done set, issues no start pulse, and raises `irq_o` if interrupt enable is set.
- R12: A legal go clears the sticky error flags and done, drops `irq_o`, and drives `go_o` high for exactly one cycle with `go_func_o` and `go_unit_o` holding the function and unit.
- R13: A `xfer_done_i` strobe sets done, ORs `xfer_err_i` into the sticky flags (bit 5 CRC, 4 parity, 3 data late, 2 record length, 1 bad tape, 0 nonexistent memory), and raises `irq_o` if interrupt enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| byte_i | input | 1 | Byte-wide write when 1 |
| addr_i | input | 4 | Bits 3:1 word offset, bit 0 byte lane |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for the addressed register |
| unit_online_i | input | NUM_UNITS | Per-unit online |
| unit_bot_i | input | NUM_UNITS | Per-unit at beginning of tape |
| unit_wlock_i | input | NUM_UNITS | Per-unit write locked |
| unit_rewind_i | input | NUM_UNITS | Per-unit rewinding |
| unit_eof_i | input | NUM_UNITS | Per-unit file mark seen |
| unit_eot_i | input | NUM_UNITS | Per-unit past end of tape |
| unit_busy_i | input | NUM_UNITS | Per-unit operation in progress |
| xfer_done_i | input | 1 | Operation completion strobe |
| xfer_err_i | input | 6 | Error flags accompanying completion |
| done_o | output | 1 | Controller done |
| err_o | output | 1 | Error summary |
| irq_o | output | 1 | Interrupt request |
| go_o | output | 1 | One-cycle start pulse |
| go_func_o | output | 3 | Function code of the started operation |
| go_unit_o | output | 3 | Unit of the started operation |

## Verification
Read data is combinational, so the bench samples `rdata_o` one nanosecond after presenting the offset, before the edge that toggles the read lines. Every write and completion strobe takes effect at the next rising edge. The bench therefore samples `done_o`, `err_o`, `irq_o` and the start-pulse outputs at the falling edge that follows. That is the only cycle in which `go_o` is high, and one cycle later the bench confirms that it has fallen. Status bits driven by unit inputs are sampled after the inputs have been changed at a falling edge and allowed to settle.

// File: rtl/tape_pkg.sv
package tape_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned UNIT_W = 3;
  localparam int unsigned MAX_UNITS = 1 << UNIT_W;
  localparam int unsigned XERR_W = 6;

  localparam logic [2:0] OFF_STAT = 3'd0;
  localparam logic [2:0] OFF_CMD  = 3'd1;
  localparam logic [2:0] OFF_BCNT = 3'd2;
  localparam logic [2:0] OFF_MADR = 3'd3;
  localparam logic [2:0] OFF_DBUF = 3'd4;
  localparam logic [2:0] OFF_RLIN = 3'd5;

  localparam logic [2:0] FN_WRITE = 3'd2;
  localparam logic [2:0] FN_WMARK = 3'd3;
  localparam logic [2:0] FN_WGAP  = 3'd6;

  typedef struct packed {
    logic online;
    logic bot;
    logic wlock;
    logic rew;
    logic eof;
    logic eot;
    logic busy;
  } unit_st_t;

  typedef struct packed {
    logic ill;
    logic crc;
    logic par;
    logic dlt;
    logic rle;
    logic bad;
    logic nxm;
  } sticky_t;
endpackage

// File: rtl/tape_lane_merge.sv
module tape_lane_merge #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] wdata_i,
  input  logic         byte_i,
  input  logic         hi_i,
  output logic [W-1:0] merged_o
);
  localparam int unsigned HB = W / 2;

  always_comb begin
    if (!byte_i)   merged_o = wdata_i;
    else if (hi_i) merged_o = {wdata_i[HB-1:0], cur_i[HB-1:0]};
    else           merged_o = {cur_i[W-1:HB], wdata_i[HB-1:0]};
  end
endmodule

// File: rtl/tape_unit_sel.sv
module tape_unit_sel
  import tape_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 8
) (
  input  logic [NUM_UNITS-1:0] online_i,
  input  logic [NUM_UNITS-1:0] bot_i,
  input  logic [NUM_UNITS-1:0] wlock_i,
  input  logic [NUM_UNITS-1:0] rew_i,
  input  logic [NUM_UNITS-1:0] eof_i,
  input  logic [NUM_UNITS-1:0] eot_i,
  input  logic [NUM_UNITS-1:0] busy_i,
  input  logic [UNIT_W-1:0]    sel_i,
  output unit_st_t             st_o
);
  unit_st_t pad [MAX_UNITS];

  // absent units look offline and idle
  for (genvar g = 0; g < MAX_UNITS; g++) begin : g_pad
    if (g < NUM_UNITS) begin : g_real
      assign pad[g] = '{online: online_i[g], bot: bot_i[g], wlock: wlock_i[g],
                        rew: rew_i[g], eof: eof_i[g], eot: eot_i[g], busy: busy_i[g]};
    end else begin : g_none
      assign pad[g] = '0;
    end
  end

  assign st_o = pad[sel_i];
endmodule

// File: rtl/tape_cmd_ctrl.sv
module tape_cmd_ctrl
  import tape_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [WORD_W-1:0] cmd_wd_i,
  input  unit_st_t          cur_st_i,
  input  unit_st_t          new_st_i,
  input  logic              xfer_done_i,
  input  logic [XERR_W-1:0] xfer_err_i,
  output logic [WORD_W-1:0] cmd_rd_o,
  output sticky_t           sticky_o,
  output logic [UNIT_W-1:0] unit_o,
  output logic [2:0]        func_o,
  output logic              soft_init_o,
  output logic              done_o,
  output logic              err_o,
  output logic              irq_o,
  output logic              go_o
);
  logic [2:0]        func_q;
  logic [1:0]        ext_q;
  logic              ie_q;
  logic              done_q;
  logic [UNIT_W-1:0] unit_q;
  logic              psel_q;
  logic [1:0]        den_q;
  sticky_t           sticky_q;
  logic              irq_q;
  logic              go_q;

  logic              accept;
  logic              bad_go;
  logic [2:0]        wfunc;

  assign err_o = (|sticky_q) | cur_st_i.eof | cur_st_i.eot;
  assign accept = cmd_we_i & done_q;
  assign soft_init_o = accept & cmd_wd_i[12];
  assign wfunc = cmd_wd_i[3:1];
  assign bad_go = !new_st_i.online || new_st_i.busy ||
                  (new_st_i.wlock && (wfunc == FN_WRITE || wfunc == FN_WMARK || wfunc == FN_WGAP));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      func_q   <= '0;
      ext_q    <= '0;
      ie_q     <= 1'b0;
      done_q   <= 1'b1;
      unit_q   <= '0;
      psel_q   <= 1'b0;
      den_q    <= '0;
      sticky_q <= '0;
      irq_q    <= 1'b0;
      go_q     <= 1'b0;
    end else begin
      go_q <= 1'b0;
      if (xfer_done_i) begin
        done_q       <= 1'b1;
        sticky_q.crc <= sticky_q.crc | xfer_err_i[5];
        sticky_q.par <= sticky_q.par | xfer_err_i[4];
        sticky_q.dlt <= sticky_q.dlt | xfer_err_i[3];
        sticky_q.rle <= sticky_q.rle | xfer_err_i[2];
        sticky_q.bad <= sticky_q.bad | xfer_err_i[1];
        sticky_q.nxm <= sticky_q.nxm | xfer_err_i[0];
        if (ie_q) irq_q <= 1'b1;
      end
      if (cmd_we_i && !done_q) begin
        sticky_q.ill <= 1'b1;
      end else if (soft_init_o) begin
        func_q   <= '0;
        ext_q    <= '0;
        ie_q     <= 1'b0;
        done_q   <= 1'b1;
        unit_q   <= '0;
        psel_q   <= 1'b0;
        den_q    <= '0;
        sticky_q <= '0;
        irq_q    <= 1'b0;
      end else if (accept) begin
        if (!cmd_wd_i[6])                       irq_q <= 1'b0;
        else if ((err_o || done_q) && !ie_q)    irq_q <= 1'b1;
        func_q <= cmd_wd_i[3:1];
        ext_q  <= cmd_wd_i[5:4];
        ie_q   <= cmd_wd_i[6];
        unit_q <= cmd_wd_i[10:8];
        psel_q <= cmd_wd_i[11];
        den_q  <= cmd_wd_i[14:13];
        if (cmd_wd_i[0]) begin
          if (bad_go) begin
            sticky_q.ill <= 1'b1;
            if (cmd_wd_i[6]) irq_q <= 1'b1;
          end else begin
            sticky_q <= '0;
            done_q   <= 1'b0;
            irq_q    <= 1'b0;
            go_q     <= 1'b1;
          end
        end
      end
    end
  end

  assign cmd_rd_o = {err_o, den_q, 1'b0, psel_q, unit_q, done_q, ie_q, ext_q, func_q, 1'b0};
  assign sticky_o = sticky_q;
  assign unit_o   = unit_q;
  assign func_o   = func_q;
  assign done_o   = done_q;
  assign irq_o    = irq_q;
  assign go_o     = go_q;
endmodule

// File: rtl/tape_ctl_regs.sv
module tape_ctl_regs
  import tape_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic                 byte_i,
  input  logic [3:0]           addr_i,
  input  logic [15:0]          wdata_i,
  output logic [15:0]          rdata_o,
  input  logic [NUM_UNITS-1:0] unit_online_i,
  input  logic [NUM_UNITS-1:0] unit_bot_i,
  input  logic [NUM_UNITS-1:0] unit_wlock_i,
  input  logic [NUM_UNITS-1:0] unit_rewind_i,
  input  logic [NUM_UNITS-1:0] unit_eof_i,
  input  logic [NUM_UNITS-1:0] unit_eot_i,
  input  logic [NUM_UNITS-1:0] unit_busy_i,
  input  logic                 xfer_done_i,
  input  logic [5:0]           xfer_err_i,
  output logic                 done_o,
  output logic                 err_o,
  output logic                 irq_o,
  output logic                 go_o,
  output logic [2:0]           go_func_o,
  output logic [2:0]           go_unit_o
);
  localparam int unsigned DB_W = WORD_W / 2;

  logic [2:0]        off;
  logic              hi;
  logic [WORD_W-1:0] bcnt_q, madr_q, cmd_rd;
  logic [DB_W-1:0]   dbuf_q;
  logic              rlin_q;
  logic [WORD_W-1:0] cmd_m, bcnt_m, madr_m, dbuf_m;
  logic              soft_init;
  sticky_t           sticky;
  unit_st_t          cur_st, new_st;
  logic [UNIT_W-1:0] unit_sel;
  logic [WORD_W-1:0] stat_word;

  assign off = addr_i[3:1];
  assign hi  = addr_i[0];

  tape_lane_merge #(.W(WORD_W)) u_m_cmd (
    .cur_i(cmd_rd), .wdata_i(wdata_i), .byte_i(byte_i), .hi_i(hi), .merged_o(cmd_m));
  tape_lane_merge #(.W(WORD_W)) u_m_bcnt (
    .cur_i(bcnt_q), .wdata_i(wdata_i), .byte_i(byte_i), .hi_i(hi), .merged_o(bcnt_m));
  tape_lane_merge #(.W(WORD_W)) u_m_madr (
    .cur_i(madr_q), .wdata_i(wdata_i), .byte_i(byte_i), .hi_i(hi), .merged_o(madr_m));
  tape_lane_merge #(.W(WORD_W)) u_m_dbuf (
    .cur_i({{DB_W{1'b0}}, dbuf_q}), .wdata_i(wdata_i), .byte_i(byte_i), .hi_i(hi),
    .merged_o(dbuf_m));

  tape_unit_sel #(.NUM_UNITS(NUM_UNITS)) u_sel_cur (
    .online_i(unit_online_i), .bot_i(unit_bot_i), .wlock_i(unit_wlock_i),
    .rew_i(unit_rewind_i), .eof_i(unit_eof_i), .eot_i(unit_eot_i), .busy_i(unit_busy_i),
    .sel_i(unit_sel), .st_o(cur_st));

  // go legality judged on the unit being written, not the one held
  tape_unit_sel #(.NUM_UNITS(NUM_UNITS)) u_sel_new (
    .online_i(unit_online_i), .bot_i(unit_bot_i), .wlock_i(unit_wlock_i),
    .rew_i(unit_rewind_i), .eof_i(unit_eof_i), .eot_i(unit_eot_i), .busy_i(unit_busy_i),
    .sel_i(cmd_m[10:8]), .st_o(new_st));

  tape_cmd_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cmd_we_i(wr_en_i && off == OFF_CMD), .cmd_wd_i(cmd_m),
    .cur_st_i(cur_st), .new_st_i(new_st),
    .xfer_done_i(xfer_done_i), .xfer_err_i(xfer_err_i),
    .cmd_rd_o(cmd_rd), .sticky_o(sticky), .unit_o(unit_sel), .func_o(go_func_o),
    .soft_init_o(soft_init), .done_o(done_o), .err_o(err_o), .irq_o(irq_o), .go_o(go_o));

  assign go_unit_o = unit_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bcnt_q <= '0;
      madr_q <= '0;
      dbuf_q <= '0;
      rlin_q <= 1'b0;
    end else if (soft_init) begin
      bcnt_q <= '0;
      madr_q <= '0;
      dbuf_q <= '0;
      rlin_q <= 1'b0;
    end else begin
      if (wr_en_i && off == OFF_BCNT) bcnt_q <= bcnt_m;
      if (wr_en_i && off == OFF_MADR) madr_q <= madr_m;
      if (wr_en_i && off == OFF_DBUF && !(byte_i && hi)) dbuf_q <= dbuf_m[DB_W-1:0];
      if (rd_en_i && off == OFF_RLIN) rlin_q <= ~rlin_q;
    end
  end

  assign stat_word = {sticky.ill, cur_st.eof, sticky.crc, sticky.par, sticky.dlt, cur_st.eot,
                      sticky.rle, sticky.bad, sticky.nxm, cur_st.online, cur_st.bot,
                      2'b00, cur_st.wlock, cur_st.rew, ~cur_st.busy};

  always_comb begin
    unique case (off)
      OFF_STAT: rdata_o = stat_word;
      OFF_CMD:  rdata_o = cmd_rd;
      OFF_BCNT: rdata_o = bcnt_q;
      OFF_MADR: rdata_o = madr_q;
      OFF_DBUF: rdata_o = {{DB_W{1'b0}}, dbuf_q};
      OFF_RLIN: rdata_o = {~rlin_q, 15'd0};
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tape_ctl_regs_chk.sv
module tape_ctl_regs_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [3:0]  addr_i,
  input logic [15:0] rdata_o,
  input logic        xfer_done_i,
  input logic        done_o,
  input logic        err_o,
  input logic        irq_o,
  input logic        go_o
);
  // R12
  go_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) go_o |=> !go_o);
  // R12
  go_clears_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) go_o |-> !done_o);
  // R9
  err_summary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[3:1] == 3'd0) |-> (err_o == (|rdata_o[15:7])));
  // R5
  stat_zero_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[3:1] == 3'd0) |-> (rdata_o[4:3] == 2'b00));
  // R8
  irq_needs_ie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[3:1] == 3'd1) |-> (!irq_o || rdata_o[6]));
  // R6
  busy_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i[3:1] == 3'd1 && !done_o && !xfer_done_i) |=> (!done_o && !go_o));
endmodule

bind tape_ctl_regs tape_ctl_regs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i), .rdata_o(rdata_o),
  .xfer_done_i(xfer_done_i), .done_o(done_o), .err_o(err_o), .irq_o(irq_o), .go_o(go_o));

// File: tb/tape_ctl_regs_bench.sv
module tape_ctl_regs_bench;
  localparam int unsigned NU = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, byte_w = 1'b0;
  logic [3:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [NU-1:0] on_v = '0, bot_v = '0, wl_v = '0, rw_v = '0, eof_v = '0, eot_v = '0, busy_v = '0;
  logic xdone = 1'b0;
  logic [5:0] xerr = '0;
  logic done, err, irq, go;
  logic [2:0] gfunc, gunit;

  int n_chk = 0, n_fail = 0;
  logic go_seen;
  logic [15:0] rv;
  logic [15:0] m_bc = '0, m_ca = '0, m_db = '0;

  always #4 clk = ~clk;

  tape_ctl_regs #(.NUM_UNITS(NU)) u_tape_ctl_regs (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .byte_i(byte_w),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .unit_online_i(on_v), .unit_bot_i(bot_v), .unit_wlock_i(wl_v), .unit_rewind_i(rw_v),
    .unit_eof_i(eof_v), .unit_eot_i(eot_v), .unit_busy_i(busy_v),
    .xfer_done_i(xdone), .xfer_err_i(xerr),
    .done_o(done), .err_o(err), .irq_o(irq), .go_o(go), .go_func_o(gfunc), .go_unit_o(gunit));

  function automatic logic [15:0] merge(logic [15:0] cur, logic [15:0] d, logic b, logic h);
    if (!b) return d;
    return h ? {d[7:0], cur[7:0]} : {cur[15:8], d[7:0]};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] off, logic b, logic h, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; byte_w = b; addr = {off, h}; wdata = d;
    @(negedge clk);
    go_seen = go;
    wr_en = 1'b0; byte_w = 1'b0;
  endtask

  task automatic rd(logic [2:0] off, output logic [15:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = {off, 1'b0};
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rchk(string req, logic [2:0] off, logic [15:0] exp);
    logic [15:0] v;
    rd(off, v);
    chk(req, v, exp);
  endtask

  task automatic xfer(logic [5:0] f);
    @(negedge clk);
    xdone = 1'b1; xerr = f;
    @(negedge clk);
    xdone = 1'b0; xerr = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 done", {15'd0, done}, 16'd1);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 err", {15'd0, err}, 16'd0);
    rchk("R1 cmd", 3'd1, 16'h0080);
    rchk("R1 bcnt", 3'd2, 16'h0000);
    rchk("R1 madr", 3'd3, 16'h0000);
    rchk("R1 dbuf", 3'd4, 16'h0000);
    rchk("R5 stat unit0 offline idle", 3'd0, 16'h0001);
    rchk("R2 off6", 3'd6, 16'h0000);
    rchk("R2 off7", 3'd7, 16'h0000);

    // R10 read lines toggle
    rchk("R10 first", 3'd5, 16'h8000);
    rchk("R10 second", 3'd5, 16'h0000);

    // R3 random word and byte writes against a model
    for (int i = 0; i < 150; i++) begin
      logic [2:0] off;
      logic b, h;
      logic [15:0] d;
      off = 3'(2 + ($urandom % 3));
      b = 1'($urandom); h = 1'($urandom); d = 16'($urandom);
      wr(off, b, h, d);
      case (off)
        3'd2: m_bc = merge(m_bc, d, b, h);
        3'd3: m_ca = merge(m_ca, d, b, h);
        default: if (!(b && h)) m_db = {8'd0, d[7:0]};
      endcase
      rchk("R3 random", off, off == 3'd2 ? m_bc : off == 3'd3 ? m_ca : m_db);
    end
    wr(3'd4, 1'b0, 1'b0, 16'h12AB);
    rchk("R3 dbuf word", 3'd4, 16'h00AB);
    wr(3'd4, 1'b1, 1'b1, 16'h0055);
    rchk("R3 dbuf high ignored", 3'd4, 16'h00AB);
    wr(3'd4, 1'b1, 1'b0, 16'h003C);
    rchk("R3 dbuf low byte", 3'd4, 16'h003C);

    // R2 read-only offsets
    wr(3'd0, 1'b0, 1'b0, 16'hFFFF);
    rchk("R2 status write ignored", 3'd0, 16'h0001);
    wr(3'd5, 1'b0, 1'b0, 16'hFFFF);
    rchk("R2 read lines write ignored", 3'd5, 16'h8000);

    // R4 command layout
    wr(3'd1, 1'b0, 1'b0, 16'h6F7E);
    rchk("R4 cmd fields", 3'd1, 16'h6FFE);
    chk("R8 ie rise with done", {15'd0, irq}, 16'd1);
    wr(3'd1, 1'b0, 1'b0, 16'h6F3E);
    chk("R8 ie clear drops", {15'd0, irq}, 16'd0);
    wr(3'd1, 1'b1, 1'b0, 16'h0040);
    rchk("R4 cmd low byte", 3'd1, 16'h6FC0);
    chk("R8 ie set by byte", {15'd0, irq}, 16'd1);
    wr(3'd1, 1'b1, 1'b1, 16'h0003);
    rchk("R4 cmd high byte", 3'd1, 16'h03C0);
    wr(3'd1, 1'b0, 1'b0, 16'h0300);
    chk("R8 drop", {15'd0, irq}, 16'd0);

    // R5 / R9 status from selected unit
    @(negedge clk);
    on_v[3] = 1'b1; bot_v[3] = 1'b1; wl_v[3] = 1'b1; rw_v[3] = 1'b1; eof_v[3] = 1'b1; eot_v[3] = 1'b1;
    rchk("R5 stat unit3", 3'd0, 16'h4467);
    chk("R9 err from eof", {15'd0, err}, 16'd1);
    rchk("R9 cmd err bit", 3'd1, 16'h8380);
    @(negedge clk);
    bot_v[3] = 1'b0; rw_v[3] = 1'b0; eof_v[3] = 1'b0; eot_v[3] = 1'b0;
    rchk("R5 stat unit3 plain", 3'd0, 16'h0045);

    // R11 write-locked write functions
    wr(3'd1, 1'b0, 1'b0, 16'h0305);
    chk("R11 wlock write no go", {15'd0, go_seen}, 16'd0);
    chk("R11 done kept", {15'd0, done}, 16'd1);
    rchk("R11 illegal flag", 3'd0, 16'h8045);
    wr(3'd1, 1'b0, 1'b0, 16'h030D);
    chk("R11 wlock gap no go", {15'd0, go_seen}, 16'd0);

    // R12 legal go
    wr(3'd1, 1'b0, 1'b0, 16'h0303);
    chk("R12 go pulse", {15'd0, go_seen}, 16'd1);
    chk("R12 go func", {13'd0, gfunc}, 16'd1);
    chk("R12 go unit", {13'd0, gunit}, 16'd3);
    chk("R12 done cleared", {15'd0, done}, 16'd0);
    chk("R12 errors cleared", {15'd0, err}, 16'd0);
    @(negedge clk);
    chk("R12 pulse one cycle", {15'd0, go}, 16'd0);

    // R6 write while busy
    wr(3'd1, 1'b0, 1'b0, 16'h0340);
    rchk("R6 cmd unchanged", 3'd1, 16'h8302);
    chk("R6 irq unchanged", {15'd0, irq}, 16'd0);
    chk("R6 no go", {15'd0, go_seen}, 16'd0);

    // R13 completion
    xfer(6'b100001);
    chk("R13 done", {15'd0, done}, 16'd1);
    chk("R13 no irq ie clear", {15'd0, irq}, 16'd0);
    rchk("R13 flags", 3'd0, 16'hA0C5);
    wr(3'd1, 1'b0, 1'b0, 16'h0340);
    chk("R8 ie rise on error", {15'd0, irq}, 16'd1);

    // R11 busy and offline
    @(negedge clk);
    busy_v[3] = 1'b1;
    wr(3'd1, 1'b0, 1'b0, 16'h0343);
    chk("R11 busy no go", {15'd0, go_seen}, 16'd0);
    chk("R11 busy irq", {15'd0, irq}, 16'd1);
    rchk("R11 busy stat", 3'd0, 16'hA0C4);
    @(negedge clk);
    busy_v[3] = 1'b0;
    wr(3'd1, 1'b0, 1'b0, 16'h0543);
    chk("R11 offline no go", {15'd0, go_seen}, 16'd0);
    rchk("R11 offline stat", 3'd0, 16'hA081);

    // R12 / R13 legal go with interrupts enabled
    wr(3'd1, 1'b0, 1'b0, 16'h0343);
    chk("R12 go with ie", {15'd0, go_seen}, 16'd1);
    chk("R12 irq dropped", {15'd0, irq}, 16'd0);
    xfer(6'b000000);
    chk("R13 irq raised", {15'd0, irq}, 16'd1);
    rchk("R13 clean stat", 3'd0, 16'h0045);
    @(negedge clk);
    wl_v[3] = 1'b0;
    wr(3'd1, 1'b0, 1'b0, 16'h034D);
    chk("R11 gap unlocked go", {15'd0, go_seen}, 16'd1);
    chk("R12 gap func", {13'd0, gfunc}, 16'd6);
    xfer(6'b000000);

    // R7 init via high byte
    wr(3'd1, 1'b1, 1'b1, 16'h0010);
    rchk("R7 cmd", 3'd1, 16'h0080);
    chk("R7 irq", {15'd0, irq}, 16'd0);
    chk("R7 done", {15'd0, done}, 16'd1);
    rchk("R7 bcnt", 3'd2, 16'h0000);
    rchk("R7 madr", 3'd3, 16'h0000);
    rchk("R7 dbuf", 3'd4, 16'h0000);
    rchk("R7 read lines", 3'd5, 16'h8000);
    rchk("R7 stat", 3'd0, 16'h0001);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule